// File: doc/BRIEF.md
# Memory Scrub and Fill Engine

This block is a bus master that walks an address range word by word. It has two jobs. In scrub mode it reads every word. When the memory reports a correctable error on one of those reads, the engine repairs the word in place: it reads the word again and writes the returned, corrected data back. That re-read and write-back form one locked pair, so no other master can reach the location between them. In fill mode it writes a fixed pattern to every word of the range, which is how a memory protected by error codes is brought into a known state.

Software sets a first address, a last address, a two-bit mode and a fill pattern, then gives a one-cycle `go` pulse. The engine samples all of these when it accepts the pulse and raises `busy`. When it completes the transaction at the last address, it drops `busy`, sets `done` and pulses `irq` for one cycle. If the bus answers any transaction with an error, the engine stops. It then sets `fault`, holds the failing word address on `fault_addr` and also pulses `irq`.

The bus is a single-beat request/ready handshake. The master holds `bus_req` with its address, direction, write data and lock until a cycle in which `bus_ready` is high. That cycle completes the transaction, and `bus_rdata`, `bus_err` and `bus_ce` belong to it. Addresses count words.

The control state machine has five states:
- ST_IDLE: waiting for a `go` pulse.
- ST_READ: a scrub read is outstanding.
- ST_LOCK_RD: the locked re-read is outstanding.
- ST_LOCK_WR: the locked write-back is outstanding.
- ST_FILL: a pattern write is outstanding.

It has these transitions:
- ST_IDLE→ST_READ: `go` with mode 00.
- ST_IDLE→ST_FILL: `go` with mode 01.
- ST_READ→ST_LOCK_RD: a clean read with the correctable-error flag set.
- ST_READ→ST_READ: a clean read without the flag, at an address other than the last one. The engine moves to the next word.
- ST_LOCK_RD→ST_LOCK_WR: the re-read completes.
- ST_LOCK_WR→ST_READ: the write-back completes at an address other than the last one.
- ST_FILL→ST_FILL: a pattern write completes at an address other than the last one.
- Any busy state→ST_IDLE: the last address completes, or a transaction ends in an error.

Top module: `mem_sweeper`

## Requirements
- R1: After reset `busy`, `done`, `irq`, `fault`, `bus_req` and `bus_lock` are all 0.
- R2: `go` with `mode` = 2'b00 starts a scrub. The engine issues reads (`bus_write`=0) starting at `start_addr`, moves up by one word after each completed read, and stops after the read at `end_addr`.
- R3: `go` with `mode` = 2'b01 starts a fill. The engine writes the `fill_data` value sampled at `go` to every word from `start_addr` up to `end_addr`, once each and in ascending order.
- R4: When a scrub read completes with `bus_ce`=1 and `bus_err`=0, the next two transactions go to the same address. The first is a read. The second is a write whose data equals the `bus_rdata` returned by that re-read. After the pair the walk moves on to the next word.
- R5: `bus_lock` is 1 during the re-read and the write-back of R4, and 0 during every other transaction and while idle. It drops in the cycle after the write-back completes.
- R6: In the cycle after the final transaction completes, `busy` is 0, `done` is 1 and `irq` is 1. `irq` is 0 in the cycle after that.
- R7: A transaction that completes with `bus_err`=1 stops the engine. In the next cycle `busy` is 0, `fault` is 1, `done` is 0, `irq` is 1, and `fault_addr` equals that transaction's address.
- R8: `go` is ignored while `busy` is 1, and also when `mode[1]` is 1. In both cases the engine issues no transactions and its address sequence does not change.
- R9: While `bus_req` is 1 and `bus_ready` is 0, `bus_req`, `bus_addr`, `bus_write`, `bus_wdata` and `bus_lock` hold their values.
- R10: An accepted `go` clears `done` and `fault` and raises `busy` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| go | input | 1 | Start pulse |
| mode | input | 2 | 00 scrub, 01 fill, 1x reserved |
| start_addr | input | ADDR_W | First word address |
| end_addr | input | ADDR_W | Last word address |
| fill_data | input | DATA_W | Fill pattern |
| bus_req | output | 1 | Transaction request |
| bus_addr | output | ADDR_W | Word address |
| bus_write | output | 1 | 1 write, 0 read |
| bus_wdata | output | DATA_W | Write data |
| bus_lock | output | 1 | Bus lock for the repair pair |
| bus_ready | input | 1 | Transaction completes this cycle |
| bus_rdata | input | DATA_W | Read data, valid with ready |
| bus_err | input | 1 | Error response, valid with ready |
| bus_ce | input | 1 | Correctable-error flag, valid with ready |
| busy | output | 1 | Engine running |
| done | output | 1 | Last walk finished cleanly |
| irq | output | 1 | One-cycle completion or fault pulse |
| fault | output | 1 | Last walk stopped on an error |
| fault_addr | output | ADDR_W | Address of the failing transaction |

## Verification
The engine accepts a `go` pulse on the next rising edge. Its first request, with `busy` high and `done` and `fault` low, is visible in the cycle after that edge. Each later request is visible one cycle after the completing edge of the one before it. `done`, `fault`, `fault_addr` and `irq` are registered and are due exactly one cycle after the final or failing transaction completes; `irq` falls one cycle after that. The bench acts as the memory slave with random stall lengths. It samples and drives on the falling edge, checks every request against an address, direction, lock and data sequence it predicts itself, and samples each status output in exactly those cycles.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ    = 3'd1,
        ST_LOCK_RD = 3'd2,
        ST_LOCK_WR = 3'd3,
        ST_FILL    = 3'd4
    } sweep_state_t;

    localparam logic [1:0] MODE_SCRUB = 2'b00;
    localparam logic [1:0] MODE_FILL  = 2'b01;

endpackage

// File: rtl/sweep_addr_walker.sv
module sweep_addr_walker #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] last_addr_in,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_end
);

    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            last_q <= '0;
        end else if (load) begin
            addr   <= first_addr;
            last_q <= last_addr_in;
        end else if (step) begin
            addr   <= addr + 1'b1;
        end
    end

    assign at_end = (addr == last_q);

    // R2: a step never happens on the final word
    p_no_step_past_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !at_end);

endmodule

// File: rtl/sweep_fsm.sv
module sweep_fsm
    import sweep_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [1:0]        mode,
    input  logic              bus_ready,
    input  logic              bus_err,
    input  logic              bus_ce,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              at_end,
    output sweep_state_t      state,
    output logic              load,
    output logic              step,
    output logic              finish,
    output logic              fault_ev,
    output logic              bus_req,
    output logic              bus_write,
    output logic              bus_lock,
    output logic [DATA_W-1:0] fix_data
);

    sweep_state_t nxt;
    logic         capture;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // corrected word returned by the locked re-read
    always_ff @(posedge clk) begin
        if (!rst_n)       fix_data <= '0;
        else if (capture) fix_data <= bus_rdata;
    end

    // transitions and events
    always_comb begin
        nxt      = state;
        load     = 1'b0;
        step     = 1'b0;
        finish   = 1'b0;
        fault_ev = 1'b0;
        capture  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (go && mode == MODE_SCRUB) begin
                    nxt  = ST_READ;
                    load = 1'b1;
                end else if (go && mode == MODE_FILL) begin
                    nxt  = ST_FILL;
                    load = 1'b1;
                end
            end
            ST_READ: begin
                if (bus_ready) begin
                    if (bus_err) begin
                        nxt      = ST_IDLE;
                        fault_ev = 1'b1;
                    end else if (bus_ce) begin
                        nxt = ST_LOCK_RD;
                    end else if (at_end) begin
                        nxt    = ST_IDLE;
                        finish = 1'b1;
                    end else begin
                        step = 1'b1;
                    end
                end
            end
            ST_LOCK_RD: begin
                if (bus_ready) begin
                    if (bus_err) begin
                        nxt      = ST_IDLE;
                        fault_ev = 1'b1;
                    end else begin
                        nxt     = ST_LOCK_WR;
                        capture = 1'b1;
                    end
                end
            end
            ST_LOCK_WR, ST_FILL: begin
                if (bus_ready) begin
                    if (bus_err) begin
                        nxt      = ST_IDLE;
                        fault_ev = 1'b1;
                    end else if (at_end) begin
                        nxt    = ST_IDLE;
                        finish = 1'b1;
                    end else begin
                        nxt  = (state == ST_LOCK_WR) ? ST_READ : ST_FILL;
                        step = 1'b1;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // bus outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_write = 1'b0;
        bus_lock  = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_READ:    bus_req = 1'b1;
            ST_LOCK_RD: begin bus_req = 1'b1; bus_lock = 1'b1; end
            ST_LOCK_WR: begin bus_req = 1'b1; bus_lock = 1'b1; bus_write = 1'b1; end
            ST_FILL:    begin bus_req = 1'b1; bus_write = 1'b1; end
            default:    ;
        endcase
    end

    // R4: a clean re-read is followed by the locked write-back
    p_pair_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK_RD && bus_ready && !bus_err) |=> (state == ST_LOCK_WR && bus_lock && bus_write));

    // R4: a flagged scrub read leads to the locked re-read
    p_ce_enters_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && bus_ready && !bus_err && bus_ce) |=> (state == ST_LOCK_RD && bus_lock && !bus_write));

    // R5: lock released after the write-back completes
    p_lock_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK_WR && bus_ready) |=> !bus_lock);

    // R8: reserved mode does not start the engine
    p_bad_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && go && mode[1]) |=> state == ST_IDLE);

    // R1: idle means a quiet bus
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!bus_req && !bus_lock));

endmodule

// File: rtl/sweep_status.sv
module sweep_status #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              finish,
    input  logic              fault_ev,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              done,
    output logic              irq,
    output logic              fault,
    output logic [ADDR_W-1:0] fault_addr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            irq        <= 1'b0;
            fault      <= 1'b0;
            fault_addr <= '0;
        end else begin
            irq <= finish | fault_ev;
            if (start) begin
                done  <= 1'b0;
                fault <= 1'b0;
            end
            if (finish) done <= 1'b1;
            if (fault_ev) begin
                fault      <= 1'b1;
                fault_addr <= cur_addr;
            end
        end
    end

    // R7: a walk ends either cleanly or in a fault, never both
    p_done_fault_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R10: an accepted start clears both flags
    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !fault));

endmodule

// File: rtl/mem_sweeper.sv
module mem_sweeper
    import sweep_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_lock,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_err,
    input  logic              bus_ce,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic              fault,
    output logic [ADDR_W-1:0] fault_addr
);

    sweep_state_t      state;
    logic              load, step, finish, fault_ev, at_end;
    logic [DATA_W-1:0] fix_data;
    logic [DATA_W-1:0] pattern_q;

    sweep_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .mode      (mode),
        .bus_ready (bus_ready),
        .bus_err   (bus_err),
        .bus_ce    (bus_ce),
        .bus_rdata (bus_rdata),
        .at_end    (at_end),
        .state     (state),
        .load      (load),
        .step      (step),
        .finish    (finish),
        .fault_ev  (fault_ev),
        .bus_req   (bus_req),
        .bus_write (bus_write),
        .bus_lock  (bus_lock),
        .fix_data  (fix_data)
    );

    sweep_addr_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .first_addr   (start_addr),
        .last_addr_in (end_addr),
        .step         (step),
        .addr         (bus_addr),
        .at_end       (at_end)
    );

    sweep_status #(.ADDR_W(ADDR_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (load),
        .finish     (finish),
        .fault_ev   (fault_ev),
        .cur_addr   (bus_addr),
        .done       (done),
        .irq        (irq),
        .fault      (fault),
        .fault_addr (fault_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)    pattern_q <= '0;
        else if (load) pattern_q <= fill_data;
    end

    assign bus_wdata = (state == ST_LOCK_WR) ? fix_data : pattern_q;
    assign busy      = (state != ST_IDLE);

    // R9: request held steady while stalled
    p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_write)
                                     && $stable(bus_wdata) && $stable(bus_lock)));

    // R7: failing address reported
    p_fault_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready && bus_err) |=> (fault && !busy && fault_addr == $past(bus_addr)));

    // R6: interrupt is a single-cycle pulse
    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6: done only while stopped
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2: an unflagged clean completion advances by one word
    p_stride_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready && !bus_err && !bus_lock && !(bus_ce && state == ST_READ) && !at_end)
        |=> bus_addr == ADDR_W'($past(bus_addr) + 1'b1));

endmodule

// File: tb/mem_sweeper_test.sv
module mem_sweeper_test;

    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] end_addr = '0;
    logic [DW-1:0] fill_data = '0;
    logic          bus_req, bus_write, bus_lock;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ready = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_err = 1'b0;
    logic          bus_ce = 1'b0;
    logic          busy, done, irq, fault;
    logic [AW-1:0] fault_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [DW-1:0] mem [0:255];

    mem_sweeper #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .mode(mode),
        .start_addr(start_addr), .end_addr(end_addr), .fill_data(fill_data),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_wdata(bus_wdata), .bus_lock(bus_lock), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .bus_ce(bus_ce),
        .busy(busy), .done(done), .irq(irq), .fault(fault), .fault_addr(fault_addr)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] seed_word(input int i);
        return (32'h9E3779B9 * (i + 1)) ^ 32'h0000_5A5A;
    endfunction

    // m: mode, s/e: range, ce_pct: chance of a flagged read,
    // err_at: index of transaction answered with an error (-1: none), poke: go while busy
    task automatic run_op(input logic [1:0] m, input int s, input int e, input int ce_pct,
                          input int err_at, input bit poke);
        int exp_a = s;
        int phase = 0;
        int n = 0;
        bit fin = 1'b0;
        bit hit_err = 1'b0;
        logic [DW-1:0] pat = $urandom;
        @(negedge clk);
        mode = m; start_addr = AW'(s); end_addr = AW'(e); fill_data = pat; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(busy == 1'b1 && done == 1'b0 && fault == 1'b0, "R10", {busy, done, fault}, 3'b100);
        while (!fin) begin
            int wait_cnt = 0;
            int stall;
            logic [AW-1:0] a0;
            logic w0, l0;
            logic [DW-1:0] d0;
            bit do_err, do_ce;
            while (!bus_req && wait_cnt < 20) begin
                @(negedge clk);
                wait_cnt++;
            end
            stall = (poke && n == 0) ? 2 : int'($urandom % 3);
            a0 = bus_addr; w0 = bus_write; l0 = bus_lock; d0 = bus_wdata;
            for (int k = 0; k < stall; k++) begin
                if (poke && n == 0 && k == 0) begin
                    go = 1'b1; mode = 2'b00; start_addr = AW'(s + 50);
                end
                @(negedge clk);
                go = 1'b0;
                chk(bus_req && bus_addr == a0 && bus_write == w0 && bus_lock == l0 && bus_wdata == d0,
                    "R9", {bus_req, bus_addr}, {1'b1, a0});
            end
            chk(bus_req == 1'b1 && bus_addr == AW'(exp_a), (m == 2'b01) ? "R3" : "R2",
                bus_addr, AW'(exp_a));
            if (poke && n == 0)
                chk(bus_addr == AW'(s), "R8", bus_addr, AW'(s));
            chk(bus_write == (m == 2'b01 || phase == 2), "R4", bus_write, (m == 2'b01 || phase == 2));
            chk(bus_lock == (phase != 0), "R5", bus_lock, (phase != 0));
            if (m == 2'b01) chk(bus_wdata == pat, "R3", bus_wdata, pat);
            if (phase == 2) chk(bus_wdata == mem[exp_a[7:0]], "R4", bus_wdata, mem[exp_a[7:0]]);
            do_err = (n == err_at);
            do_ce = (m == 2'b00 && phase == 0 && !do_err && int'($urandom % 100) < ce_pct);
            bus_err = do_err;
            bus_ce = do_ce;
            bus_rdata = (phase == 0 && do_ce) ? (mem[exp_a[7:0]] ^ 32'h0000_0100) : mem[exp_a[7:0]];
            bus_ready = 1'b1;
            @(negedge clk);
            bus_ready = 1'b0; bus_err = 1'b0; bus_ce = 1'b0;
            if (m == 2'b01 && !do_err) mem[exp_a[7:0]] = pat;
            n++;
            if (do_err) begin
                fin = 1'b1; hit_err = 1'b1;
            end else if (phase == 0 && do_ce) begin
                phase = 1;
            end else if (phase == 1) begin
                phase = 2;
            end else begin
                phase = 0;
                if (exp_a == e) fin = 1'b1;
                else exp_a++;
            end
            if (!fin && phase == 0 && n > 0 && bus_req)
                chk(bus_lock == 1'b0, "R5", bus_lock, 1'b0);
        end
        chk(busy == 1'b0 && irq == 1'b1, "R6", {busy, irq}, 2'b01);
        if (hit_err) begin
            chk(fault == 1'b1 && done == 1'b0, "R7", {fault, done}, 2'b10);
            chk(fault_addr == AW'(exp_a), "R7", fault_addr, AW'(exp_a));
        end else begin
            chk(done == 1'b1 && fault == 1'b0, "R6", {done, fault}, 2'b10);
        end
        @(negedge clk);
        chk(irq == 1'b0 && bus_req == 1'b0 && bus_lock == 1'b0, "R6", {irq, bus_req, bus_lock}, 3'b000);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) mem[i] = seed_word(i);
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && irq == 0 && fault == 0 && bus_req == 0 && bus_lock == 0,
            "R1", {busy, done, irq, fault, bus_req, bus_lock}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && bus_req == 0, "R1", {busy, bus_req}, 2'b00);

        // R2: clean scrub, no flagged words
        run_op(2'b00, 10, 14, 0, -1, 1'b0);
        // R4/R5: every read flagged
        run_op(2'b00, 20, 22, 100, -1, 1'b0);
        // R3: fill, with go poked while busy (R8)
        run_op(2'b01, 30, 35, 0, -1, 1'b1);
        // R3: single-word range
        run_op(2'b01, 40, 40, 0, -1, 1'b0);
        // R7: error on third transaction of a scrub
        run_op(2'b00, 50, 56, 0, 2, 1'b0);
        // R7: error during the locked re-read, then R10 clears it
        run_op(2'b00, 60, 62, 100, 1, 1'b0);
        run_op(2'b00, 60, 61, 0, -1, 1'b0);

        // R8: reserved mode ignored
        @(negedge clk);
        mode = 2'b10; start_addr = 32'd5; end_addr = 32'd6; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(busy == 1'b0 && bus_req == 1'b0, "R8", {busy, bus_req}, 2'b00);
            @(negedge clk);
        end

        // random mix
        for (int r = 0; r < 10; r++) begin
            int s = int'($urandom % 200);
            int len = int'($urandom % 8);
            logic [1:0] m = ($urandom % 2 == 0) ? 2'b00 : 2'b01;
            int ea = ($urandom % 3 == 0) ? int'($urandom % 6) : -1;
            run_op(m, s, s + len, 35, ea, 1'b0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule